// File: doc/BRIEF.md
# Decoupled Packet Scheduler Controller

This controller sits in front of a buffering scheduler store. Its job is to keep the outgoing packet stream apart from two incoming streams: data packets and control messages. It decides, cycle by cycle, whether to take a data packet, take a control message or emit a packet. It pulses an insert strobe to the store for each accepted packet and a remove strobe for each emitted one. How the store orders its packets is not part of this block.

The controller has two phases, gathering and emitting. It keeps three counts: data packets taken since the last forced emission, control messages taken since the last forced emission, and packets currently held in the store. Taking QUOTA_DATA packets, or QUOTA_CTRL control messages while the store holds something, forces the emitting phase. That phase accepts nothing until one packet leaves. While gathering, a packet may also leave whenever nothing acceptable is waiting at the inputs. As a result, the gap between emissions is bounded by the quotas and not by input traffic.

Top module: `pkt_decouple_ctrl`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge) the block is gathering with all counts zero: `in_ready` and `cfg_ready` are 1, and `out_valid` is 0.
- R2: Each accepted data packet (`in_valid && in_ready`) raises `store_ins` for that one cycle and adds one to the occupancy. The QUOTA_DATA-th packet accepted since the data count last cleared clears the count and moves the block to emitting.
- R3: While emitting, `in_ready` and `cfg_ready` are 0. The next emission returns the block to gathering.
- R4: When occupancy is nonzero, the QUOTA_CTRL-th accepted control message since the control count last cleared clears the count and moves the block to emitting.
- R5: When occupancy is zero, accepted control messages never leave gathering. The control count then stops at QUOTA_CTRL-1, so the first control message taken after a packet arrives forces emitting.
- R6: `out_valid` is 1 only when occupancy is nonzero. Each emission (`out_valid && out_ready`) raises `store_rem` for that cycle and removes one from the occupancy. While emitting, `out_valid` is 1.
- R7: While gathering, `out_valid` is 1 exactly when occupancy is nonzero, no acceptable data packet is presented, and `cfg_valid` is 0.
- R8: A data packet and a control message are never taken in the same cycle. When a data packet is accepted, `cfg_ready` is 0.
- R9: Occupancy never exceeds DEPTH. At DEPTH, `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Data packet offered |
| in_ready | output | 1 | Data packet can be taken |
| cfg_valid | input | 1 | Control message offered |
| cfg_ready | output | 1 | Control message can be taken |
| out_valid | output | 1 | A packet is ready to leave |
| out_ready | input | 1 | Downstream takes the packet |
| store_ins | output | 1 | One-cycle insert strobe to the store |
| store_rem | output | 1 | One-cycle remove strobe to the store |

## Verification
The assertions assume that the store really holds as many packets as the controller counts. They also assume that every input is sampled only at rising edges, with no other timing relation between the three handshakes. The stimulus changes inputs only on falling edges. It mixes directed phases (bursts, control floods into an empty store, filling to DEPTH) with pseudo-random valid and ready patterns. A valid may therefore drop before it is accepted, and the assertions do not rely on valid being held.

// File: rtl/pkt_decouple_ctrl.sv
module pkt_decouple_ctrl #(
  parameter int QUOTA_DATA = 3,
  parameter int QUOTA_CTRL = 2,
  parameter int DEPTH      = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic cfg_valid,
  output logic cfg_ready,
  output logic out_valid,
  input  logic out_ready,
  output logic store_ins,
  output logic store_rem
);
  localparam int DQW = $clog2(QUOTA_DATA + 1);
  localparam int CQW = $clog2(QUOTA_CTRL + 1);
  localparam int OW  = $clog2(DEPTH + 1);
  localparam logic [DQW-1:0] DQ_LAST = DQW'(QUOTA_DATA - 1);
  localparam logic [CQW-1:0] CQ_LAST = CQW'(QUOTA_CTRL - 1);
  localparam logic [OW-1:0]  OCC_MAX = OW'(DEPTH);

  logic           emitting;
  logic [DQW-1:0] dq;
  logic [CQW-1:0] cq;
  logic [OW-1:0]  occ;
  logic           data_take, cfg_take, in_busy;

  assign in_ready  = !emitting && (occ != OCC_MAX);
  assign data_take = in_valid && in_ready;
  assign cfg_ready = !emitting && !data_take;
  assign cfg_take  = cfg_valid && cfg_ready;
  assign in_busy   = data_take || cfg_valid;
  assign out_valid = (occ != '0) && (emitting || !in_busy);
  assign store_ins = data_take;
  assign store_rem = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      emitting <= 1'b0;
      dq       <= '0;
      cq       <= '0;
      occ      <= '0;
    end else begin
      if (data_take) begin
        occ <= occ + 1'b1;
        if (dq == DQ_LAST) begin
          dq       <= '0;
          emitting <= 1'b1;
        end else begin
          dq <= dq + 1'b1;
        end
      end else if (cfg_take) begin
        if (cq == CQ_LAST) begin
          if (occ != '0) begin
            cq       <= '0;
            emitting <= 1'b1;
          end
        end else begin
          cq <= cq + 1'b1;
        end
      end else if (store_rem) begin
        occ      <= occ - 1'b1;
        emitting <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pkt_decouple_ctrl_chk.sv
module pkt_decouple_ctrl_chk #(
  parameter int DEPTH = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       cfg_valid,
  input logic       cfg_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic       store_ins,
  input logic       store_rem,
  input logic       emitting,
  input logic [7:0] occ_w
);
  a_r3_emit_blocks_inputs: assert property (@(posedge clk) disable iff (rst)
    emitting |-> (!in_ready && !cfg_ready));
  a_r3_emit_returns: assert property (@(posedge clk) disable iff (rst)
    store_rem |=> !emitting);
  a_r6_out_needs_data: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (occ_w != 0));
  a_r6_remove_decrements: assert property (@(posedge clk) disable iff (rst)
    store_rem |=> (occ_w == $past(occ_w) - 8'd1));
  a_r2_insert_increments: assert property (@(posedge clk) disable iff (rst)
    store_ins |=> (occ_w == $past(occ_w) + 8'd1));
  a_r7_inputs_first: assert property (@(posedge clk) disable iff (rst)
    (!emitting && out_valid) |-> (!cfg_valid && !(in_valid && in_ready)));
  a_r8_one_input: assert property (@(posedge clk) disable iff (rst)
    !((in_valid && in_ready) && (cfg_valid && cfg_ready)));
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (occ_w <= 8'(DEPTH)) && ((occ_w == 8'(DEPTH)) -> !in_ready));
  a_r2_strobe_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(store_ins && store_rem));
endmodule

bind pkt_decouple_ctrl pkt_decouple_ctrl_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .out_valid(out_valid),
  .out_ready(out_ready), .store_ins(store_ins), .store_rem(store_rem),
  .emitting(emitting), .occ_w(8'(occ))
);

// File: tb/pkt_decouple_ctrl_tb_top.sv
module pkt_decouple_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int K = 3;
  localparam int M = 2;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, cfg_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, cfg_ready, out_valid, store_ins, store_rem;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_decouple_ctrl #(.QUOTA_DATA(K), .QUOTA_CTRL(M), .DEPTH(D)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .out_valid(out_valid),
    .out_ready(out_ready), .store_ins(store_ins), .store_rem(store_rem)
  );

  typedef struct packed {
    logic ir, cr, ov, si, sr;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int m_st = 0, m_occ = 0, m_dq = 0, m_cq = 0;
  int gap = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: one cycle of stimulus plus the expected outputs from the requirements
  task automatic cyc(input logic iv, input logic cv, input logic ordy);
    exp_t e;
    logic dtake, ctake, otake;
    @(negedge clk);
    in_valid = iv; cfg_valid = cv; out_ready = ordy;
    #1;
    e.ir = (m_st == 0) && (m_occ < D);
    dtake = iv && e.ir;
    e.cr = (m_st == 0) && !dtake;
    ctake = cv && e.cr;
    e.ov = (m_occ > 0) && ((m_st == 1) || (!dtake && !cv));
    otake = e.ov && ordy;
    e.si = dtake;
    e.sr = otake;
    exp_q.push_back(e);
    if (dtake) begin
      m_occ++;
      if (m_dq == K-1) begin m_dq = 0; m_st = 1; end else m_dq++;
    end else if (ctake) begin
      if (m_cq == M-1) begin
        if (m_occ > 0) begin m_cq = 0; m_st = 1; end
      end else m_cq++;
    end else if (otake) begin
      m_occ--; m_st = 0;
    end
    if (otake) gap = 0; else if (m_occ > 0) gap++;
    if (gap > K + M + 2) begin
      checks++; errors++;
      $display("FAIL R3: emission gap actual %0d expected <= %0d", gap, K+M+2);
    end
  endtask

  // monitor: pops expectations and compares them away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(in_ready,  e.ir, "R9/R3 in_ready");
        chk(cfg_ready, e.cr, "R8/R3 cfg_ready");
        chk(out_valid, e.ov, "R7/R6 out_valid");
        chk(store_ins, e.si, "R2 store_ins");
        chk(store_rem, e.sr, "R6 store_rem");
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    // R1 reset state
    chk(in_ready, 1'b1, "R1 in_ready");
    chk(cfg_ready, 1'b1, "R1 cfg_ready");
    chk(out_valid, 1'b0, "R1 out_valid");
    // R5 control flood into an empty store
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, 1'b1);
    // R2 burst to the data quota with downstream stalled, then R3 blocked
    for (int i = 0; i < K; i++) cyc(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b0);
    cyc(1'b1, 1'b1, 1'b1);
    // R5 saturated control count: the next control message forces emitting
    cyc(1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
    // R8 both inputs at once, R9 fill to DEPTH
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b1);
    // R4 control quota with a nonempty store
    for (int i = 0; i < 2*M; i++) cyc(1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
    // R7 opportunistic drain when idle
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b0, 1'b1);
    // mixed pseudo-random traffic
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0] & lfsr[3], lfsr[5] & lfsr[7] & lfsr[1], lfsr[9] | lfsr[2]);
    end
    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b0, 1'b1);
    @(negedge clk);
    #3;
    chk(out_valid, 1'b0, "R6 drained out_valid");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule